// File: doc/BRIEF.md
# Dual-Channel Receive Write Window Monitor

This block sits between a host controller and a two-channel speech decoder. In every frame it asks the host for two receive payloads, one per channel, and checks that both arrive in full while the frame's write window is still open. The host picks a channel with a select bit and then streams bytes with a strobe. The block counts those bytes for each channel. While no channel is complete it raises a request marked "first". Once one channel is complete the request stays up but the marker drops. When both channels are full the request goes low.

The window length depends on how many frames have passed since the codec started. The first frame after reset has no limit and ends only at the next frame strobe. The second frame gets a short window and every later frame a long one. Both lengths are counted in timebase ticks and have separate parameters for the 10 ms and 20 ms modes. When a window closes, each channel that is still short of data has its late flag set. A flag stays set until a later window closes with that channel complete. A write to a channel that is already full in the current frame raises a duplicate flag. Each window close reloads that flag with whether the frame just ended contained such a write.

Top module: `rx_window_monitor`

## Requirements
- R1: A channel is complete when it has received 80 bytes with `mode_20ms`=0, or 160 bytes with `mode_20ms`=1. The mode is latched at the frame strobe. Bytes beyond that count are not counted.
- R2: In the cycle after `frame_start`, `req`=1 and `req_first`=1, and both stay 1 until one channel is complete.
- R3: With exactly one channel complete, `req`=1 and `req_first`=0. With both complete, `req`=0.
- R4: A written byte goes to channel 0 when `ch_sel`=0 and to channel 1 when `ch_sel`=1.
- R5: The window of the first frame after reset ignores ticks and closes only at the next `frame_start`.
- R6: The second frame's window closes on the 16th tick (10 ms mode, and also 20 ms mode by default). Every later frame closes on the 72nd tick (10 ms) or the 152nd tick (20 ms). A byte in the closing cycle is ignored.
- R7: At each window close, `err_ch0`/`err_ch1` take the value 1 if that channel is incomplete and 0 otherwise. Between closes they hold their value.
- R8: A byte accepted for a channel that is already complete sets `dup_err` in the next cycle. At each close, `dup_err` takes 1 if the ending frame had such a write and 0 otherwise. It holds its value in between.
- R9: Bytes strobed while no window is open are ignored. They change neither the requests nor `dup_err`.
- R10: Synchronous reset clears `req`, `req_first`, both late flags and `dup_err`, and returns to the first-frame state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | Frame boundary strobe; opens a window |
| tick | input | 1 | Timebase tick (0.125 ms) |
| wr_en | input | 1 | Byte write strobe |
| ch_sel | input | 1 | Channel-notify bit: 0 selects channel 0, 1 selects channel 1 |
| mode_20ms | input | 1 | 1 selects 20 ms frame timing |
| req | output | 1 | Receive write request |
| req_first | output | 1 | Request is the first of the frame |
| err_ch0 | output | 1 | Sticky late-write flag, channel 0 |
| err_ch1 | output | 1 | Sticky late-write flag, channel 1 |
| dup_err | output | 1 | Duplicate-write flag |

## Verification
The main function is tried in three ways. First, full frames are written in both channel orders, which separates correct channel steering from a shared count. Second, the byte just before completion is compared with the completing byte, which pins the exact count in each mode. Third, the number of ticks before the payload is written is swept from zero up to the short-window length: only the last value should make both flags rise, which fixes the window boundary to the exact tick. Further frames that end complete, incomplete and with an extra byte separate the sticky reload from a plain set-only flag. Writes while no window is open separate ignored bytes from counted ones.

// File: rtl/rx_window_monitor.sv
module rx_window_monitor #(
  parameter int BYTES_10 = 80,
  parameter int BYTES_20 = 160,
  parameter int SHORT_10 = 16,
  parameter int LONG_10  = 72,
  parameter int SHORT_20 = 16,
  parameter int LONG_20  = 152
)(
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  input  logic tick,
  input  logic wr_en,
  input  logic ch_sel,
  input  logic mode_20ms,
  output logic req,
  output logic req_first,
  output logic err_ch0,
  output logic err_ch1,
  output logic dup_err
);
  localparam int BMAX = (BYTES_20 > BYTES_10) ? BYTES_20 : BYTES_10;
  localparam int TM1  = (LONG_10 > SHORT_10) ? LONG_10 : SHORT_10;
  localparam int TM2  = (LONG_20 > SHORT_20) ? LONG_20 : SHORT_20;
  localparam int TMAX = (TM1 > TM2) ? TM1 : TM2;
  localparam int CW   = $clog2(BMAX + 1);
  localparam int TW   = $clog2(TMAX + 1);

  logic          open, seen, mode_q, dup_frm;
  logic [1:0]    fidx;
  logic [CW-1:0] cnt0, cnt1;
  logic [TW-1:0] tcnt;

  wire [CW-1:0] need  = mode_q ? CW'(BYTES_20) : CW'(BYTES_10);
  wire          done0 = (cnt0 == need);
  wire          done1 = (cnt1 == need);
  wire [TW-1:0] lim   = (fidx == 2'd1) ? (mode_q ? TW'(SHORT_20) : TW'(SHORT_10))
                                       : (mode_q ? TW'(LONG_20)  : TW'(LONG_10));
  wire timed     = (fidx != 2'd0);
  wire tick_end  = open && timed && tick && (tcnt == lim - TW'(1));
  wire close_now = open && (frame_start || tick_end);
  wire take      = open && wr_en && !close_now;
  wire hit0      = take && !ch_sel;
  wire hit1      = take && ch_sel;
  wire dup_hit   = (hit0 && done0) || (hit1 && done1);

  assign req       = open && !(done0 && done1);
  assign req_first = open && !done0 && !done1;

  always_ff @(posedge clk) begin
    if (rst) begin
      open <= 1'b0; seen <= 1'b0; mode_q <= 1'b0; dup_frm <= 1'b0;
      fidx <= '0; cnt0 <= '0; cnt1 <= '0; tcnt <= '0;
      err_ch0 <= 1'b0; err_ch1 <= 1'b0; dup_err <= 1'b0;
    end else begin
      if (close_now) begin
        err_ch0 <= !done0;
        err_ch1 <= !done1;
        dup_err <= dup_frm;
        open    <= 1'b0;
      end else if (dup_hit) begin
        dup_err <= 1'b1;
      end
      if (frame_start) begin
        open    <= 1'b1;
        seen    <= 1'b1;
        mode_q  <= mode_20ms;
        fidx    <= !seen ? 2'd0 : (fidx == 2'd2 ? 2'd2 : fidx + 2'd1);
        cnt0    <= '0;
        cnt1    <= '0;
        tcnt    <= '0;
        dup_frm <= 1'b0;
      end else begin
        if (open && timed && tick) tcnt <= tcnt + TW'(1);
        if (hit0 && !done0) cnt0 <= cnt0 + CW'(1);
        if (hit1 && !done1) cnt1 <= cnt1 + CW'(1);
        if (dup_hit) dup_frm <= 1'b1;
      end
    end
  end

  AST_REQ_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (req && req_first)); // R2
  AST_BYTES_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    (cnt0 <= need) && (cnt1 <= need)); // R1
  AST_ERR_AT_CLOSE: assert property (@(posedge clk) disable iff (rst)
    ($rose(err_ch0) || $rose(err_ch1)) |-> $past(close_now)); // R7
  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (!open && !frame_start) |=> ($stable(cnt0) && $stable(cnt1))); // R9
  AST_DUP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (dup_err && !close_now) |=> dup_err); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!req && !req_first && !err_ch0 && !err_ch1 && !dup_err)); // R10
endmodule

// File: tb/rx_window_monitor_test.sv
module rx_window_monitor_test;
  localparam int B10 = 80, B20 = 160, S10 = 16, L10 = 72, S20 = 16, L20 = 152;

  logic clk = 1'b0, rst = 1'b1, frame_start = 1'b0, tick = 1'b0;
  logic wr_en = 1'b0, ch_sel = 1'b0, mode_20ms = 1'b0;
  logic req, req_first, err_ch0, err_ch1, dup_err;
  int runs = 0, fails = 0;

  always #4 clk = ~clk;

  rx_window_monitor uut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .tick(tick),
    .wr_en(wr_en), .ch_sel(ch_sel), .mode_20ms(mode_20ms),
    .req(req), .req_first(req_first), .err_ch0(err_ch0),
    .err_ch1(err_ch1), .dup_err(dup_err));

  task automatic check(string tag, logic act, logic exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_reset(logic m);
    @(negedge clk); rst = 1'b1; mode_20ms = m;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic fs();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic wr(logic ch, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wr_en = 1'b1; ch_sel = ch;
    end
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    @(negedge clk);
    check("R10 req", req, 1'b0);
    check("R10 err0", err_ch0, 1'b0);
    check("R10 dup", dup_err, 1'b0);

    // frame 0, unlimited window
    fs();
    check("R2 req", req, 1'b1);
    check("R2 first", req_first, 1'b1);
    wr(1'b0, B10 - 1);
    check("R1 first before last byte", req_first, 1'b1);
    wr(1'b0, 1);
    check("R3 first dropped", req_first, 1'b0);
    check("R3 req held", req, 1'b1);
    wr(1'b1, B10);
    check("R3 req done", req, 1'b0);
    ticks(200);
    check("R5 no close err0", err_ch0, 1'b0);
    check("R5 no close err1", err_ch1, 1'b0);
    wr(1'b1, 1);
    check("R8 dup set", dup_err, 1'b1);

    // frame 1, short window
    fs();
    check("R7 frame0 err0", err_ch0, 1'b0);
    check("R8 dup reload", dup_err, 1'b1);
    check("R2 first frame1", req_first, 1'b1);
    wr(1'b1, B10);
    check("R4 ch1 steer first", req_first, 1'b0);
    check("R4 ch1 steer req", req, 1'b1);
    ticks(S10 - 1);
    check("R6 short open", req, 1'b1);
    ticks(1);
    check("R6 short closed", req, 1'b0);
    check("R7 err0 late", err_ch0, 1'b1);
    check("R7 err1 ok", err_ch1, 1'b0);
    check("R8 dup cleared", dup_err, 1'b0);
    wr(1'b0, B10);
    wr(1'b1, 2);
    check("R9 req idle", req, 1'b0);
    check("R9 dup idle", dup_err, 1'b0);

    // frame 2, long window
    fs();
    check("R7 err0 sticky", err_ch0, 1'b1);
    wr(1'b0, B10);
    wr(1'b1, B10);
    ticks(L10 - 1);
    check("R7 err0 held before close", err_ch0, 1'b0 ^ 1'b1);
    ticks(1);
    check("R6 long close err0", err_ch0, 1'b0);
    check("R6 long close err1", err_ch1, 1'b0);

    // frame 3 empty, closed by next strobe
    fs();
    wr(1'b1, 5);
    fs();
    check("R7 fs close err0", err_ch0, 1'b1);
    check("R7 fs close err1", err_ch1, 1'b1);

    // sweep of ticks before writes in frame 1
    for (int t = 0; t <= S10; t++) begin
      do_reset(1'b0);
      fs(); wr(1'b0, B10); wr(1'b1, B10);
      fs(); ticks(t); wr(1'b0, B10); wr(1'b1, B10);
      fs();
      check($sformatf("R6 sweep t=%0d err0", t), err_ch0, (t >= S10));
      check($sformatf("R6 sweep t=%0d err1", t), err_ch1, (t >= S10));
    end

    // 20 ms mode
    do_reset(1'b1);
    fs();
    wr(1'b1, B20 - 1);
    check("R1 20ms first before last", req_first, 1'b1);
    wr(1'b1, 1);
    check("R1 20ms first dropped", req_first, 1'b0);
    wr(1'b0, B20);
    check("R1 20ms done", req, 1'b0);
    fs();
    ticks(S20 - 1);
    check("R6 20ms short open", req, 1'b1);
    ticks(1);
    check("R6 20ms short closed", req, 1'b0);
    fs();
    ticks(L20 - 1);
    check("R6 20ms long open", req, 1'b1);
    ticks(1);
    check("R6 20ms long closed", req, 1'b0);
    check("R7 20ms err1", err_ch1, 1'b1);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule